// File: doc/BRIEF.md
# External Memory Bank and Chip-Select Unit

This block drives the upper address byte and a 4-bit auxiliary output group on the external bus of an 8-bit microcontroller. It holds two registers that the core reaches through a simple register port. The first is a page register. It supplies the upper address byte whenever the core makes a data access through an 8-bit pointer, so that such accesses can reach any 256-byte page of external data memory. The second is an extension control register. Its top bit sets what the 4-bit group does.

With the mode bit clear, the group carries a bank number that extends the address space to 1 MB. The bank number appears only during cycles that use the 16-bit pointer: table reads, data reads and data writes. In every other cycle the group reads zero, so instruction fetches always stay in the first 64 KB. With the mode bit set, the group becomes four active-low chip selects. Each select covers one 16 KB quarter of the space and is decoded from the top two bits of the driven upper address byte.

Both registers are written on the clock edge. Both read back combinationally, so direct moves and read-modify-write sequences work. Both outputs follow the cycle-type and address inputs combinationally.

Top module: `xbank_csel_top`

## Requirements
- R1: After synchronous active-low reset, the page register reads 00h at register address A1h and the control register reads 70h at register address A2h. In bank mode after reset the group outputs 0000b, even during a 16-bit-pointer cycle.
- R2: A write to register address A1h with reg_wr_en high stores reg_wdata in the page register at the rising clock edge, and it reads back unchanged.
- R3: Reading address A2h returns bit 7 and bits 3..0 as last written, with bits 6..4 always 111b whatever was written to them.
- R4: When cyc_type is 5 (8-bit-pointer data read) or 6 (8-bit-pointer data write), hi_addr equals the page register.
- R5: For every other cyc_type value (0 idle, 1 fetch, 2 table read via 16-bit pointer, 3 data read via 16-bit pointer, 4 data write via 16-bit pointer), hi_addr equals core_addr[15:8].
- R6: With control bit 7 = 0 and cyc_type 2, 3 or 4, grp_out equals control bits 3..0.
- R7: With control bit 7 = 0 and any other cyc_type, grp_out is 0000b.
- R8: With control bit 7 = 1, grp_out has exactly one bit low. The low bit is bit n, where n is hi_addr[7:6] (00 gives 1110b, 01 gives 1101b, 10 gives 1011b, 11 gives 0111b), for every cyc_type.
- R9: A write to any register address other than A1h and A2h, or any cycle with reg_wr_en low, changes neither register. Reads of other addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 8 | Register address for read and write |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| cyc_type | input | 3 | Bus cycle type from the core (0..6) |
| core_addr | input | 16 | Core address |
| hi_addr | output | 8 | Upper external address byte |
| grp_out | output | 4 | Bank number or active-low chip selects |

## Verification
The vector table crosses both group modes with every cycle-type class. 16-bit-pointer cycles show the bank number, while fetch, idle and 8-bit cycles mask it to zero. This separates a bank that leaks into fetches from one that is wrongly gated off. Page values are chosen to differ from core_addr[15:8], so a swapped high-byte source shows up. In chip-select mode, 8-bit cycles whose page and core address fall in different quarters show whether the decode follows the driven byte. Directed cases cover the reset values, reserved bits written as 0 and as 1, and writes to foreign addresses or without a strobe.

// File: rtl/xb_pkg.sv
// Shared definitions for the external bank and chip-select unit.
// Assumes the core encodes its bus cycle kind in three bits as listed.
package xb_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE   = 3'd0,
        CYC_FETCH  = 3'd1,
        CYC_TBL16  = 3'd2,
        CYC_RD16   = 3'd3,
        CYC_WR16   = 3'd4,
        CYC_RD8    = 3'd5,
        CYC_WR8    = 3'd6
    } cyc_t;

    // True for cycles that address through the 16-bit pointer.
    function automatic logic is_wide(input logic [2:0] c);
        return (c == CYC_TBL16) || (c == CYC_RD16) || (c == CYC_WR16);
    endfunction

    // True for data cycles that address through the 8-bit pointer.
    function automatic logic is_paged(input logic [2:0] c);
        return (c == CYC_RD8) || (c == CYC_WR8);
    endfunction
endpackage

// File: rtl/xb_page_reg.sv
// Page register: holds the upper address byte used by 8-bit-pointer
// data cycles. Assumes register writes are single-cycle strobes.
module xb_page_reg #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'hA1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] page_q
);
    // Load on a strobed write to this register's address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (wr_en && addr == REG_ADDR)
            page_q <= wdata;
    end
endmodule

// File: rtl/xb_ctrl_reg.sv
// Extension control register: a mode bit at the top, a bank field at
// the bottom, and reserved bits between them that always read as ones.
// Assumes DATA_W > GRP_W + 1 so that at least one reserved bit exists.
module xb_ctrl_reg #(
    parameter int          DATA_W   = 8,
    parameter int          GRP_W    = 4,
    parameter logic [7:0]  REG_ADDR = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              mode_cs,
    output logic [GRP_W-1:0]  bank_q,
    output logic [DATA_W-1:0] rd_view
);
    localparam int RSV_W = DATA_W - 1 - GRP_W;

    // Store only the mode and bank bits; reserved bits carry no state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_cs <= 1'b0;
            bank_q  <= '0;
        end else if (wr_en && addr == REG_ADDR) begin
            mode_cs <= wdata[DATA_W-1];
            bank_q  <= wdata[GRP_W-1:0];
        end
    end

    // Merge stored bits with the fixed reserved pattern for reads.
    always_comb rd_view = {mode_cs, {RSV_W{1'b1}}, bank_q};
endmodule

// File: rtl/xb_grp_drv.sv
// Drives the 4-bit group either as a gated bank number or as active-low
// chip selects decoded from the top bits of the driven upper byte.
// Assumes GRP_W is a power of two.
module xb_grp_drv #(
    parameter int DATA_W = 8,
    parameter int GRP_W  = 4
) (
    input  logic              mode_cs,
    input  logic              wide_cyc,
    input  logic [GRP_W-1:0]  bank,
    input  logic [DATA_W-1:0] hi_byte,
    output logic [GRP_W-1:0]  grp
);
    localparam int SEL_W = $clog2(GRP_W);

    logic [SEL_W-1:0] sel;
    logic [GRP_W-1:0] cs_n;

    assign sel = hi_byte[DATA_W-1 -: SEL_W];

    // One active-low select per address region.
    for (genvar g = 0; g < GRP_W; g++) begin : g_cs
        assign cs_n[g] = (sel != SEL_W'(g));
    end

    // Choose chip selects or the bank gated by the cycle kind.
    always_comb begin
        if (mode_cs)
            grp = cs_n;
        else if (wide_cyc)
            grp = bank;
        else
            grp = '0;
    end
endmodule

// File: rtl/xbank_csel_top.sv
// Top of the external bank and chip-select unit. Selects the upper
// address byte, drives the 4-bit group and serves register reads.
// Assumes cyc_type and core_addr are stable for the whole bus cycle.
module xbank_csel_top #(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter int          GRP_W     = 4,
    parameter logic [7:0]  PAGE_ADDR = 8'hA1,
    parameter logic [7:0]  CTRL_ADDR = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [2:0]        cyc_type,
    input  logic [ADDR_W-1:0] core_addr,
    output logic [DATA_W-1:0] hi_addr,
    output logic [GRP_W-1:0]  grp_out
);
    import xb_pkg::*;

    logic [DATA_W-1:0] page_q;
    logic [DATA_W-1:0] ctrl_view;
    logic [GRP_W-1:0]  bank_q;
    logic              mode_cs;

    xb_page_reg #(.DATA_W(DATA_W), .REG_ADDR(PAGE_ADDR)) u_page (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .page_q(page_q)
    );

    xb_ctrl_reg #(.DATA_W(DATA_W), .GRP_W(GRP_W), .REG_ADDR(CTRL_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .mode_cs(mode_cs), .bank_q(bank_q),
        .rd_view(ctrl_view)
    );

    // Upper byte comes from the page register on 8-bit-pointer cycles.
    always_comb begin
        if (is_paged(cyc_type))
            hi_addr = page_q;
        else
            hi_addr = core_addr[ADDR_W-1 -: DATA_W];
    end

    xb_grp_drv #(.DATA_W(DATA_W), .GRP_W(GRP_W)) u_grp (
        .mode_cs(mode_cs), .wide_cyc(is_wide(cyc_type)), .bank(bank_q),
        .hi_byte(hi_addr), .grp(grp_out)
    );

    // Register read mux; unmapped addresses read zero.
    always_comb begin
        if (reg_addr == PAGE_ADDR)
            reg_rdata = page_q;
        else if (reg_addr == CTRL_ADDR)
            reg_rdata = ctrl_view;
        else
            reg_rdata = '0;
    end
endmodule

// File: rtl/xb_chk.sv
// Property checker for xbank_csel_top, attached by bind below.
module xb_chk #(
    parameter int          DATA_W    = 8,
    parameter int          GRP_W     = 4,
    parameter logic [7:0]  PAGE_ADDR = 8'hA1,
    parameter logic [7:0]  CTRL_ADDR = 8'hA2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        reg_addr,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [2:0]        cyc_type,
    input logic [DATA_W-1:0] hi_addr,
    input logic [GRP_W-1:0]  grp_out,
    input logic [DATA_W-1:0] page_q,
    input logic              mode_cs
);
    localparam int SEL_W = $clog2(GRP_W);

    // R2: a strobed page write is visible one edge later
    p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == PAGE_ADDR) |=> (page_q == $past(reg_wdata)));

    // R3: reserved control bits always read as ones
    p_rsv_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CTRL_ADDR) |-> (reg_rdata[DATA_W-2:GRP_W] == '1));

    // R4: paged cycles present the page register on the upper byte
    p_page_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == 3'd5 || cyc_type == 3'd6) |-> (hi_addr == page_q));

    // R7: bank mode keeps the group at zero outside 16-bit-pointer cycles
    p_fetch_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cs && !(cyc_type inside {3'd2, 3'd3, 3'd4})) |-> (grp_out == '0));

    // R8: select mode has exactly one line low
    p_cs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cs |-> ($countones(grp_out) == GRP_W - 1));

    // R8: the low line matches the top bits of the upper byte
    p_cs_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cs |-> (grp_out[hi_addr[DATA_W-1 -: SEL_W]] == 1'b0));
endmodule

bind xbank_csel_top xb_chk #(
    .DATA_W(DATA_W), .GRP_W(GRP_W), .PAGE_ADDR(PAGE_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_type(cyc_type),
    .hi_addr(hi_addr), .grp_out(grp_out), .page_q(page_q), .mode_cs(mode_cs)
);

// File: tb/sim_xbank_csel_top.sv
// Bench for xbank_csel_top: vector table, then directed cases.
module sim_xbank_csel_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic        reg_wr_en;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [2:0]  cyc_type;
    logic [15:0] core_addr;
    logic [7:0]  hi_addr;
    logic [3:0]  grp_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    xbank_csel_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_type(cyc_type),
        .core_addr(core_addr), .hi_addr(hi_addr), .grp_out(grp_out)
    );

    // {ctrl, page, cyc, addr, exp_hi, exp_grp}
    localparam int NV = 12;
    localparam logic [46:0] VEC [NV] = '{
        {8'h05, 8'h3C, 3'd2, 16'h1234, 8'h12, 4'h5},  // R5 R6 table read
        {8'h05, 8'h3C, 3'd1, 16'h1234, 8'h12, 4'h0},  // R7 fetch
        {8'h0A, 8'h3C, 3'd5, 16'hABCD, 8'h3C, 4'h0},  // R4 R7 paged read
        {8'h0A, 8'h3C, 3'd6, 16'hABCD, 8'h3C, 4'h0},  // R4 R7 paged write
        {8'h0A, 8'h77, 3'd3, 16'hFF00, 8'hFF, 4'hA},  // R6 data read
        {8'h0F, 8'h77, 3'd4, 16'h0001, 8'h00, 4'hF},  // R6 data write
        {8'h80, 8'h00, 3'd1, 16'h0000, 8'h00, 4'hE},  // R8 region 0
        {8'h80, 8'h00, 3'd0, 16'h4000, 8'h40, 4'hD},  // R8 region 1
        {8'h8F, 8'h11, 3'd2, 16'h8000, 8'h80, 4'hB},  // R8 region 2
        {8'h80, 8'h22, 3'd5, 16'hC123, 8'h22, 4'hE},  // R8 decode uses page
        {8'h8A, 8'hFF, 3'd6, 16'h0000, 8'hFF, 4'h7},  // R8 region 3 via page
        {8'h00, 8'h00, 3'd0, 16'hFFFF, 8'hFF, 4'h0}   // R5 R7 idle
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; reg_addr = 8'h00; reg_wr_en = 1'b0; reg_wdata = 8'h00;
        cyc_type = 3'd0; core_addr = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values and reset group state in a bank cycle
        rd_check("R1 page reset", 8'hA1, 8'h00);
        rd_check("R1 ctrl reset", 8'hA2, 8'h70);
        cyc_type = 3'd2; core_addr = 16'h5678; #1;
        check("R1 group after reset", {12'h0, grp_out}, 16'h0000);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            wr_reg(8'hA2, VEC[i][46:39]);
            wr_reg(8'hA1, VEC[i][38:31]);
            cyc_type  = VEC[i][30:28];
            core_addr = VEC[i][27:12];
            #1;
            check("R4/R5 hi_addr", {8'h00, hi_addr}, {8'h00, VEC[i][11:4]});
            check("R6/R7/R8 grp_out", {12'h0, grp_out}, {12'h0, VEC[i][3:0]});
        end

        // R2 page write and readback
        wr_reg(8'hA1, 8'h5A);
        rd_check("R2 page readback", 8'hA1, 8'h5A);

        // R3 reserved bits read as ones whatever is written
        wr_reg(8'hA2, 8'h00);
        rd_check("R3 ctrl write 00", 8'hA2, 8'h70);
        wr_reg(8'hA2, 8'h8F);
        rd_check("R3 ctrl write 8F", 8'hA2, 8'hFF);
        wr_reg(8'hA2, 8'h73);
        rd_check("R3 ctrl write 73", 8'hA2, 8'h73);

        // R9 foreign address writes and unstrobed writes change nothing
        wr_reg(8'hA3, 8'hFF);
        rd_check("R9 page kept", 8'hA1, 8'h5A);
        rd_check("R9 ctrl kept", 8'hA2, 8'h73);
        rd_check("R9 foreign read", 8'hA3, 8'h00);
        @(negedge clk);
        reg_addr = 8'hA2; reg_wdata = 8'h8C; reg_wr_en = 1'b0;
        @(negedge clk);
        rd_check("R9 no strobe ctrl", 8'hA2, 8'h73);
        cyc_type = 3'd3; core_addr = 16'hC000; #1;
        check("R9 bank mode kept", {12'h0, grp_out}, 16'h0003);

        // R1 reset clears registers again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_check("R1 page re-reset", 8'hA1, 8'h00);
        rd_check("R1 ctrl re-reset", 8'hA2, 8'h70);

        finish_run();
    end
endmodule